// File: doc/BRIEF.md
# Bus Cycle Breakpoint Matcher

This block watches each cycle on a processor bus and compares it with one programmed break condition. Software loads a 32-bit break address as two 16-bit halves, a condition byte that qualifies the cycle, and a control word. Each bus cycle arrives with an address, a master tag (CPU or DMA), a kind (instruction fetch or data), a direction and an access size. When a cycle meets every part of the condition, the block latches a break event.

A matching instruction fetch tags the fetched instruction. The break is then taken before that instruction runs, and the saved return PC is the break address itself. A matching data access is reported after the access completes. In that case the saved PC is the next-instruction address that the CPU supplies. The event stays latched until software clears it.

The request goes to the CPU as a level. A separate take signal says when the break may be entered: only at an instruction boundary that accepts interrupts, and only after any pending address-error exception has been handled.

Top module: `brk_matcher`

## Requirements
- R1: Out of reset the condition byte is 0x00, the control word is 0x0000, and brk_flag, brk_req, fetch_tag and brk_take are low. The break address is {high half, low half}: select 0 writes the high half, select 1 the low half, select 2 the condition byte (data bits 7:0) and select 3 the control word.
- R2: The condition byte holds four 2-bit fields, from bit 7 down: master (01 CPU, 10 DMA, 11 either), kind (01 fetch, 10 data, 11 either), direction (01 read, 10 write, 11 either) and size. A value of 00 in master, kind or direction disables all matching.
- R3: A fetch cycle that matches raises fetch_tag for one cycle, on the clock edge after the cycle. On that same edge brk_flag sets and saved_pc takes the fetch address.
- R4: Condition 0x54 (CPU, fetch, read) breaks on a read fetch of the break address. Condition 0x58 (CPU, fetch, write) never breaks on a fetch, because fetches are reads.
- R5: With an odd break address and a fetch condition, sequential even-address fetches never match.
- R6: A data cycle that matches sets brk_flag on the next edge and loads saved_pc from next_pc. fetch_tag stays low.
- R7: While control bit 0 (interrupt enable) is clear, no event is latched and brk_req stays low.
- R8: brk_flag and saved_pc hold until a control-word write with bit 1 set clears the flag. A later match while the flag is set does not change saved_pc.
- R9: brk_req equals brk_flag while interrupt enable is set. brk_take is high only while brk_req and cpu_accept are both high.
- R10: A size field of 00 ignores the access size. Any other value (01 byte, 10 word, 11 longword) must equal bus_size.
- R11: While addr_err is high, brk_take stays low even if a break is pending. A fetch of an odd break address after a branch still latches the event, and the break is taken once addr_err drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address high, 1 address low, 2 condition, 3 control |
| cfg_wdata | input | 16 | Write data |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 32 | Cycle address |
| bus_dma | input | 1 | 1 DMA master, 0 CPU |
| bus_fetch | input | 1 | 1 instruction fetch, 0 data |
| bus_write | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | 01 byte, 10 word, 11 longword |
| next_pc | input | 32 | Address after the current instruction |
| cpu_accept | input | 1 | CPU is at a boundary that accepts interrupts |
| addr_err | input | 1 | Address-error exception pending |
| fetch_tag | output | 1 | Fetched instruction carries a break |
| brk_flag | output | 1 | Latched break event |
| saved_pc | output | 32 | Return PC for the break |
| brk_req | output | 1 | Break request level |
| brk_take | output | 1 | Break may be entered now |

## Verification
fetch_tag, brk_flag and saved_pc are registered, so each is due on the first clock edge after the bus cycle that causes it. brk_req and brk_take are combinational from the flag, cpu_accept and addr_err. The scoreboard pushes one expected item when a bus cycle is driven on a falling edge. It pops and compares that item just after the next rising edge, which holds every registered result to exactly one cycle of latency. The handshake outputs are checked shortly after their inputs change on a falling edge, in the same cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int COND_W = 8;
  localparam logic [1:0] SEL_ADDR_HI = 2'd0;
  localparam logic [1:0] SEL_ADDR_LO = 2'd1;
  localparam logic [1:0] SEL_COND    = 2'd2;
  localparam logic [1:0] SEL_CTRL    = 2'd3;
  localparam int CTRL_IE_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;

  typedef struct packed {
    logic [1:0] master;
    logic [1:0] kind;
    logic [1:0] dir;
    logic [1:0] size;
  } cond_t;

  // A two-bit selector: bit 0 admits the first choice, bit 1 the second.
  function automatic logic sel_ok(input logic [1:0] sel, input logic is_second);
    return is_second ? sel[1] : sel[0];
  endfunction

  function automatic logic size_ok(input logic [1:0] sel, input logic [1:0] sz);
    return (sel == 2'b00) || (sel == sz);
  endfunction

  function automatic logic qual_match(input cond_t c, input logic dma,
                                      input logic fetch, input logic wr,
                                      input logic [1:0] sz);
    return sel_ok(c.master, dma) && sel_ok(c.kind, !fetch) &&
           sel_ok(c.dir, wr) && size_ok(c.size, sz);
  endfunction
endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [ADDR_W/2-1:0] wr_data,
  output logic [ADDR_W-1:0]   brk_addr,
  output cond_t               cond_q,
  output logic                ie_q,
  output logic                clr_pulse
);
  localparam int HALF_W = ADDR_W / 2;
  localparam int NHALF  = 2;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam logic [1:0] MY_SEL = (h == 0) ? SEL_ADDR_HI : SEL_ADDR_LO;
    logic [HALF_W-1:0] half_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= '0;
      else if (wr_en && wr_sel == MY_SEL) half_q <= wr_data;
    end
    assign brk_addr[(NHALF-1-h)*HALF_W +: HALF_W] = half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      ie_q   <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel == SEL_COND) cond_q <= cond_t'(wr_data[COND_W-1:0]);
      if (wr_sel == SEL_CTRL) ie_q   <= wr_data[CTRL_IE_BIT];
    end
  end

  assign clr_pulse = wr_en && (wr_sel == SEL_CTRL) && wr_data[CTRL_CLR_BIT];
endmodule

// File: rtl/brk_cond_match.sv
module brk_cond_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_dma,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] brk_addr,
  input  cond_t             cond,
  input  logic              ie,
  output logic              addr_eq,
  output logic              qual_ok,
  output logic              hit
);
  assign addr_eq = (bus_addr == brk_addr);
  assign qual_ok = qual_match(cond, bus_dma, bus_fetch, bus_write, bus_size);
  assign hit     = bus_valid && ie && addr_eq && qual_ok;
endmodule

// File: rtl/brk_event_latch.sv
module brk_event_latch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              is_fetch,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              clr,
  output logic              flag_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic              tag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pc_q   <= '0;
      tag_q  <= 1'b0;
    end else begin
      tag_q <= hit && is_fetch;
      if (clr) begin
        flag_q <= 1'b0;
      end else if (hit && !flag_q) begin
        flag_q <= 1'b1;
        pc_q   <= is_fetch ? bus_addr : next_pc;
      end
    end
  end
endmodule

// File: rtl/brk_matcher.sv
module brk_matcher
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_sel,
  input  logic [ADDR_W/2-1:0] cfg_wdata,
  input  logic                bus_valid,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_dma,
  input  logic                bus_fetch,
  input  logic                bus_write,
  input  logic [1:0]          bus_size,
  input  logic [ADDR_W-1:0]   next_pc,
  input  logic                cpu_accept,
  input  logic                addr_err,
  output logic                fetch_tag,
  output logic                brk_flag,
  output logic [ADDR_W-1:0]   saved_pc,
  output logic                brk_req,
  output logic                brk_take
);
  logic [ADDR_W-1:0] brk_addr;
  cond_t             cond_q;
  logic              ie_q;
  logic              clr_pulse;
  logic              addr_eq;
  logic              qual_ok;
  logic              hit;

  brk_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .brk_addr(brk_addr), .cond_q(cond_q),
    .ie_q(ie_q), .clr_pulse(clr_pulse)
  );

  brk_cond_match #(.ADDR_W(ADDR_W)) u_match (
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_dma(bus_dma),
    .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
    .brk_addr(brk_addr), .cond(cond_q), .ie(ie_q),
    .addr_eq(addr_eq), .qual_ok(qual_ok), .hit(hit)
  );

  brk_event_latch #(.ADDR_W(ADDR_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .hit(hit), .is_fetch(bus_fetch),
    .bus_addr(bus_addr), .next_pc(next_pc), .clr(clr_pulse),
    .flag_q(brk_flag), .pc_q(saved_pc), .tag_q(fetch_tag)
  );

  assign brk_req  = brk_flag && ie_q;
  assign brk_take = brk_req && cpu_accept && !addr_err;
endmodule

// File: rtl/brk_matcher_chk.sv
module brk_matcher_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_fetch,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [ADDR_W-1:0] next_pc,
  input logic              cpu_accept,
  input logic              addr_err,
  input logic              fetch_tag,
  input logic              brk_flag,
  input logic [ADDR_W-1:0] saved_pc,
  input logic              brk_req,
  input logic              brk_take,
  input logic              ie_q,
  input logic              clr_pulse,
  input logic              hit,
  input logic [7:0]        cond_bits
);
  AST_OFF_FIELD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_bits[7:6] == 2'b00 || cond_bits[5:4] == 2'b00 || cond_bits[3:2] == 2'b00) |-> !hit); // R2
  AST_TAG_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_tag |-> $past(bus_fetch)); // R3
  AST_FETCH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(brk_flag) && fetch_tag) |-> saved_pc == $past(bus_addr)); // R3
  AST_DATA_PC: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(brk_flag) && !fetch_tag) |-> saved_pc == $past(next_pc)); // R6
  AST_NO_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !brk_req); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !clr_pulse) |=> (brk_flag && $stable(saved_pc))); // R8
  AST_TAKE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_accept |-> !brk_take); // R9
  AST_ADDR_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !brk_take); // R11
endmodule

bind brk_matcher brk_matcher_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_fetch(bus_fetch), .bus_addr(bus_addr),
  .next_pc(next_pc), .cpu_accept(cpu_accept), .addr_err(addr_err),
  .fetch_tag(fetch_tag), .brk_flag(brk_flag), .saved_pc(saved_pc),
  .brk_req(brk_req), .brk_take(brk_take), .ie_q(ie_q),
  .clr_pulse(clr_pulse), .hit(hit), .cond_bits(cond_q)
);

// File: tb/brk_matcher_bench.sv
`timescale 1ns/100ps
module brk_matcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_dma = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = 2'b01;
  logic [31:0] next_pc = '0;
  logic        cpu_accept = 1'b0, addr_err = 1'b0;
  logic        fetch_tag, brk_flag, brk_req, brk_take;
  logic [31:0] saved_pc;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic        tag;
    logic        flag;
    logic [31:0] pc;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  brk_matcher u_brk_matcher (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_dma(bus_dma), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .bus_size(bus_size), .next_pc(next_pc), .cpu_accept(cpu_accept),
    .addr_err(addr_err), .fetch_tag(fetch_tag), .brk_flag(brk_flag),
    .saved_pc(saved_pc), .brk_req(brk_req), .brk_take(brk_take)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: results of a bus cycle are due on the next rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.req, " fetch_tag"}, 32'(fetch_tag), 32'(e.tag));
        check({e.req, " brk_flag"},  32'(brk_flag),  32'(e.flag));
        if (e.flag) check({e.req, " saved_pc"}, saved_pc, e.pc);
      end
    end
  end

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_cfg(input logic [31:0] a, input logic [7:0] c, input logic [15:0] ctrl);
    wr_reg(2'd0, a[31:16]);
    wr_reg(2'd1, a[15:0]);
    wr_reg(2'd2, {8'h00, c});
    wr_reg(2'd3, ctrl);
  endtask

  // Driver: one bus cycle, expected result pushed to the scoreboard.
  task automatic bus_cyc(input logic [31:0] a, input logic dma, input logic fetch,
                         input logic wr, input logic [1:0] sz, input logic [31:0] npc,
                         input logic etag, input logic eflag, input logic [31:0] epc,
                         input string req);
    exp_t e;
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_dma = dma; bus_fetch = fetch;
    bus_write = wr; bus_size = sz; next_pc = npc;
    e.tag = etag; e.flag = eflag; e.pc = epc; e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic hs(input logic acc, input logic aerr, input logic ereq,
                    input logic etake, input string req);
    @(negedge clk);
    cpu_accept = acc; addr_err = aerr;
    #1;
    check({req, " brk_req"},  32'(brk_req),  32'(ereq));
    check({req, " brk_take"}, 32'(brk_take), 32'(etake));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flag", 32'(brk_flag), 0);
    check("R1 reset req",  32'(brk_req), 0);
    check("R1 reset tag",  32'(fetch_tag), 0);
    rst_n = 1'b1;

    // Read-fetch break at 0x00000404
    set_cfg(32'h0000_0404, 8'h54, 16'h0001);
    bus_cyc(32'h400, 0, 1, 0, 2'b10, 0, 0, 0, 0, "R4 seq fetch 0x400");
    bus_cyc(32'h402, 0, 1, 0, 2'b10, 0, 0, 0, 0, "R4 seq fetch 0x402");
    bus_cyc(32'h404, 0, 1, 0, 2'b10, 0, 1, 1, 32'h404, "R3 R4 R10 fetch hit 0x404");
    bus_cyc(32'h406, 0, 1, 0, 2'b10, 0, 0, 1, 32'h404, "R8 flag held");
    hs(0, 0, 1, 0, "R9 no accept");
    hs(1, 0, 1, 1, "R9 accept");
    hs(1, 1, 1, 0, "R11 addr err masks take");
    hs(0, 0, 1, 0, "R9 idle");
    wr_reg(2'd3, 16'h0003);
    #1 check("R8 cleared", 32'(brk_flag), 0);

    // Write-fetch condition never breaks
    set_cfg(32'h0015_389C, 8'h58, 16'h0001);
    bus_cyc(32'h0015_389C, 0, 1, 0, 2'b10, 0, 0, 0, 0, "R4 write-fetch cond");
    bus_cyc(32'h0015_389C, 0, 0, 0, 2'b10, 0, 0, 0, 0, "R4 data read not fetch");

    // Odd break address
    set_cfg(32'h0003_0147, 8'h54, 16'h0001);
    bus_cyc(32'h0003_0144, 0, 1, 0, 2'b10, 0, 0, 0, 0, "R5 even 0x30144");
    bus_cyc(32'h0003_0146, 0, 1, 0, 2'b10, 0, 0, 0, 0, "R5 even 0x30146");
    bus_cyc(32'h0003_0148, 0, 1, 0, 2'b10, 0, 0, 0, 0, "R5 even 0x30148");
    bus_cyc(32'h0000_0147, 0, 1, 0, 2'b10, 0, 0, 0, 0, "R1 high half differs");
    @(negedge clk) addr_err = 1'b1;
    bus_cyc(32'h0003_0147, 0, 1, 0, 2'b10, 0, 1, 1, 32'h0003_0147, "R11 odd branch fetch");
    hs(1, 1, 1, 0, "R11 addr err first");
    hs(1, 0, 1, 1, "R11 taken after addr err");
    hs(0, 0, 1, 0, "R9 idle");
    wr_reg(2'd3, 16'h0003);

    // Data breaks
    set_cfg(32'h0000_2000, 8'h6A, 16'h0001);
    bus_cyc(32'h2000, 0, 0, 1, 2'b01, 32'h1008, 0, 0, 0, "R10 byte vs word");
    bus_cyc(32'h2000, 0, 0, 0, 2'b10, 32'h1008, 0, 0, 0, "R2 read vs write");
    bus_cyc(32'h2000, 1, 0, 1, 2'b10, 32'h1008, 0, 0, 0, "R2 DMA vs CPU");
    bus_cyc(32'h2000, 0, 0, 1, 2'b10, 32'h1008, 0, 1, 32'h1008, "R6 data hit");
    wr_reg(2'd3, 16'h0003);
    wr_reg(2'd2, 16'h00EA);
    bus_cyc(32'h2000, 1, 0, 1, 2'b10, 32'h2222, 0, 1, 32'h2222, "R2 either master");
    wr_reg(2'd3, 16'h0003);

    // Disabled master field
    set_cfg(32'h0000_0404, 8'h14, 16'h0001);
    bus_cyc(32'h404, 0, 1, 0, 2'b10, 0, 0, 0, 0, "R2 master 00");

    // Interrupt enable clear
    set_cfg(32'h0000_0404, 8'h54, 16'h0000);
    bus_cyc(32'h404, 0, 1, 0, 2'b10, 0, 0, 0, 0, "R7 ie clear");
    hs(1, 0, 0, 0, "R7 no request");

    // First saved PC kept
    wr_reg(2'd3, 16'h0001);
    bus_cyc(32'h404, 0, 1, 0, 2'b10, 0, 1, 1, 32'h404, "R3 refetch hit");
    wr_reg(2'd2, 16'h00EA);
    bus_cyc(32'h404, 0, 0, 1, 2'b10, 32'h999, 0, 1, 32'h404, "R8 pc kept");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule